// File: doc/BRIEF.md
# Sifted-Key Filter and Eavesdrop Estimator

This block sits after the measurement stage of a two-basis key exchange. Every cycle it may accept one record for a single qubit position: the bit the sender encoded, the bit the receiver measured, and a flag that says whether the two sides used the same basis. Positions with differing bases carry no shared information and are dropped outright. Positions with the same basis are forwarded, in arrival order, as sifted key bits on a strobed output. The same positions are compared for equality, and each disagreement counts as an error.

Records are grouped into frames of a fixed number of valid records. When the last record of a frame arrives, the block reports the error count, the sifted count and a resend verdict. It decides without a divider: the frame is judged eavesdropped when the error share, in percent, exceeds a threshold set by parameter. It gives the same verdict when no position survived sifting, because then no key exists. A frame-start pulse drops a partly filled frame. After a frame completes, the next one starts on its own.

Top module: `key_sift_monitor`

## Requirements
- R1: While reset is held low at a clock edge, key_valid, done and resend are 0 and err_count and sift_count are 0 after that edge.
- R2: A valid record whose basis-match flag is 1 produces key_valid = 1 in the next cycle, with key_bit equal to that record's received bit. Key bits leave in arrival order.
- R3: A valid record whose basis-match flag is 0 produces no key_valid and changes neither the error count nor the sifted count.
- R4: A matched record counts as an error exactly when its sent and received bits differ (an equality test that gives 0).
- R5: done is high for exactly one cycle, in the cycle after the FRAME_LEN-th valid record of a frame is accepted. Cycles with in_valid low do not advance the frame.
- R6: err_count and sift_count show the totals of the finished frame while done is high, and hold them until the next done.
- R7: resend is 1 when err_count*100 > THRESH_PCT*sift_count (strictly greater), and 0 when the two are equal or the product is smaller.
- R8: resend is 1 for a frame whose sifted count is 0.
- R9: frame_start discards the partial frame. A valid record in the same cycle counts as the first record of the new frame.
- R10: After done, the next valid record begins a new frame with zeroed counts and needs no frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Drops the partial frame and restarts counting |
| in_valid | input | 1 | Record present this cycle |
| in_tx_bit | input | 1 | Bit encoded by the sender |
| in_rx_bit | input | 1 | Bit measured by the receiver |
| in_basis_match | input | 1 | 1 when both sides used the same basis |
| key_valid | output | 1 | Strobe for one sifted key bit |
| key_bit | output | 1 | Sifted key bit (receiver's bit) |
| done | output | 1 | One-cycle end-of-frame pulse |
| err_count | output | CNT_W | Errors among sifted positions in the last frame |
| sift_count | output | CNT_W | Sifted positions in the last frame |
| resend | output | 1 | Eavesdrop verdict; key must be exchanged again |

## Verification
The bench runs consecutive frames through the block. The frames are built so that a fault in sifting stands apart from a fault in comparison: full-match frames with no error, with errors just below the threshold, exactly at it and above it; frames where the differing bits all fall on unmatched positions; and a frame where nothing matches. The two frames whose error share equals the threshold exactly separate a strict comparison from a non-strict one. Directed cases insert idle gaps inside a frame, restart a frame partway through with a concurrent record, and observe that the outputs hold after done.

// File: rtl/sift_pkg.sv
// Shared types for the key sifting datapath.
// Assumes nothing beyond a single clock domain.
package sift_pkg;

    // One qubit position as seen after measurement.
    typedef struct packed {
        logic tx;     // bit encoded by the sender
        logic rx;     // bit measured by the receiver
        logic match;  // bases agreed
    } qubit_rec_t;

    // Multiplier used to turn an error fraction into percent.
    localparam int unsigned PERCENT_SCALE = 100;

endpackage

// File: rtl/sift_filter.sv
// Sifting stage: keeps matched-basis records, flags disagreements and
// registers each kept bit onto the key output stream.
// Assumes at most one record per cycle; no back-pressure.
module sift_filter
    import sift_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  qubit_rec_t rec,
    output logic       kept,
    output logic       err_hit,
    output logic       key_valid,
    output logic       key_bit
);

    logic agree;

    // Equality test between sent and received bits.
    always_comb begin
        agree   = rec.tx ~^ rec.rx;
        kept    = in_valid && rec.match;
        err_hit = kept && !agree;
    end

    // Register the kept bit onto the key stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_valid <= 1'b0;
            key_bit   <= 1'b0;
        end else begin
            key_valid <= kept;
            key_bit   <= kept ? rec.rx : 1'b0;
        end
    end

    // R2: a key strobe only follows an accepted matched record.
    p_key_follows_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> $past(in_valid && rec.match));

    // R3: an unmatched record never yields a key strobe.
    p_skip_unmatched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rec.match) |=> !key_valid);

    // R4: an error is only raised on a kept position.
    p_err_only_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |-> kept);

endmodule

// File: rtl/sift_counter.sv
// Frame tracker: counts valid records, sifted positions and errors.
// Publishes next-state totals and a frame-end flag for the verdict stage.
// Assumes FRAME_LEN >= 1.
module sift_counter #(
    parameter int unsigned FRAME_LEN = 64,
    localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic             kept,
    input  logic             err_hit,
    output logic [CNT_W-1:0] err_next,
    output logic [CNT_W-1:0] sift_next,
    output logic             frame_end
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] pos_q, err_q, sift_q;
    logic [CNT_W-1:0] pos_base, err_base, sift_base;

    // Restart point: frame_start wipes the partial frame this cycle.
    always_comb begin
        pos_base  = frame_start ? '0 : pos_q;
        err_base  = frame_start ? '0 : err_q;
        sift_base = frame_start ? '0 : sift_q;
        err_next  = err_base + CNT_W'(err_hit);
        sift_next = sift_base + CNT_W'(kept);
        frame_end = in_valid && (pos_base == LAST_POS);
    end

    // Advance or clear the running totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            err_q  <= '0;
            sift_q <= '0;
        end else if (frame_end) begin
            pos_q  <= '0;
            err_q  <= '0;
            sift_q <= '0;
        end else if (in_valid) begin
            pos_q  <= pos_base + 1'b1;
            err_q  <= err_next;
            sift_q <= sift_next;
        end else if (frame_start) begin
            pos_q  <= '0;
            err_q  <= '0;
            sift_q <= '0;
        end
    end

    // R4: errors never outnumber sifted positions.
    p_err_le_sift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q <= sift_q);

    // R5: the position never reaches the frame length.
    p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < CNT_W'(FRAME_LEN));

    // R3: an idle cycle without restart leaves the totals alone.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !frame_start) |=> $stable(sift_q) && $stable(err_q));

endmodule

// File: rtl/sift_verdict.sv
// Verdict stage: at frame end, latches the totals and decides whether
// the key must be resent. Uses cross-multiplication in place of a divide.
// Assumes THRESH_PCT <= 100.
module sift_verdict
    import sift_pkg::*;
#(
    parameter int unsigned CNT_W      = 7,
    parameter int unsigned THRESH_PCT = 11,
    parameter int unsigned FRAME_LEN  = 64,
    localparam int unsigned PROD_W    = CNT_W + 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic [CNT_W-1:0] err_next,
    input  logic [CNT_W-1:0] sift_next,
    output logic             done,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] sift_count,
    output logic             resend
);

    localparam logic [PROD_W-1:0] SCALE = PROD_W'(PERCENT_SCALE);
    localparam logic [PROD_W-1:0] THR   = PROD_W'(THRESH_PCT);

    logic [PROD_W-1:0] err_pct, thr_lim;
    logic              verdict;

    // Compare scaled errors with scaled threshold; empty key forces resend.
    always_comb begin
        err_pct = PROD_W'(err_next) * SCALE;
        thr_lim = PROD_W'(sift_next) * THR;
        verdict = (sift_next == '0) || (err_pct > thr_lim);
    end

    // Latch the frame result and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            err_count  <= '0;
            sift_count <= '0;
            resend     <= 1'b0;
        end else begin
            done <= frame_end;
            if (frame_end) begin
                err_count  <= err_next;
                sift_count <= sift_next;
                resend     <= verdict;
            end
        end
    end

    // R8: an empty sifted key always asks for a resend.
    p_empty_resend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sift_count == '0) |-> resend);

    // R6: results hold between done pulses.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(err_count) && $stable(sift_count) && $stable(resend));

    // R5: done is a single-cycle pulse when a frame spans several records.
    generate
        if (FRAME_LEN > 1) begin : g_pulse
            p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
                done |=> !done);
        end
    endgenerate

endmodule

// File: rtl/key_sift_monitor.sv
// Top: sifts a stream of qubit records, emits the sifted key and judges
// each frame of FRAME_LEN valid records for eavesdropping.
// Assumes one record per cycle at most and a synchronous active-low reset.
module key_sift_monitor
    import sift_pkg::*;
#(
    parameter int unsigned FRAME_LEN  = 64,
    parameter int unsigned THRESH_PCT = 11,
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic             in_tx_bit,
    input  logic             in_rx_bit,
    input  logic             in_basis_match,
    output logic             key_valid,
    output logic             key_bit,
    output logic             done,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] sift_count,
    output logic             resend
);

    qubit_rec_t       rec;
    logic             kept, err_hit, frame_end;
    logic [CNT_W-1:0] err_next, sift_next;

    // Pack the incoming record.
    always_comb begin
        rec.tx    = in_tx_bit;
        rec.rx    = in_rx_bit;
        rec.match = in_basis_match;
    end

    sift_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .rec       (rec),
        .kept      (kept),
        .err_hit   (err_hit),
        .key_valid (key_valid),
        .key_bit   (key_bit)
    );

    sift_counter #(.FRAME_LEN(FRAME_LEN)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .in_valid    (in_valid),
        .kept        (kept),
        .err_hit     (err_hit),
        .err_next    (err_next),
        .sift_next   (sift_next),
        .frame_end   (frame_end)
    );

    sift_verdict #(
        .CNT_W      (CNT_W),
        .THRESH_PCT (THRESH_PCT),
        .FRAME_LEN  (FRAME_LEN)
    ) u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .err_next   (err_next),
        .sift_next  (sift_next),
        .done       (done),
        .err_count  (err_count),
        .sift_count (sift_count),
        .resend     (resend)
    );

    // R1: nothing is reported in the cycle after a reset edge.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !done && !key_valid && !resend);

endmodule

// File: tb/key_sift_monitor_tb_top.sv
module key_sift_monitor_tb_top;

    localparam int unsigned FL = 8;
    localparam int unsigned TH = 25;
    localparam int unsigned CW = $clog2(FL + 1);

    typedef struct packed {
        logic [7:0]    mask;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic [CW-1:0] exp_err;
        logic [CW-1:0] exp_sift;
        logic          exp_resend;
    } vec_t;

    // Frames fed LSB first; expected totals and verdict at THRESH 25 %.
    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'hFF, 8'hA5, 8'hA5, 4'd0, 4'd8, 1'b0},  // clean full match
        '{8'hFF, 8'hA5, 8'hA6, 4'd2, 4'd8, 1'b0},  // 25 % exactly, R7
        '{8'hFF, 8'hA5, 8'hA2, 4'd3, 4'd8, 1'b1},  // above, R7
        '{8'h0F, 8'h00, 8'hF0, 4'd0, 4'd4, 1'b0},  // diffs only unmatched, R3
        '{8'h00, 8'h12, 8'h34, 4'd0, 4'd0, 1'b1},  // nothing sifted, R8
        '{8'hF0, 8'hFF, 8'h7F, 4'd1, 4'd4, 1'b0},  // 25 % of 4, R7
        '{8'hF0, 8'hFF, 8'h3F, 4'd2, 4'd4, 1'b1},  // 50 %, R4
        '{8'hAA, 8'h55, 8'h55, 4'd0, 4'd4, 1'b0}   // alternating match
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_tx_bit = 1'b0;
    logic          in_rx_bit = 1'b0;
    logic          in_basis_match = 1'b0;
    logic          key_valid, key_bit, done, resend;
    logic [CW-1:0] err_count, sift_count;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    key_sift_monitor #(.FRAME_LEN(FL), .THRESH_PCT(TH)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start    (frame_start),
        .in_valid       (in_valid),
        .in_tx_bit      (in_tx_bit),
        .in_rx_bit      (in_rx_bit),
        .in_basis_match (in_basis_match),
        .key_valid      (key_valid),
        .key_bit        (key_bit),
        .done           (done),
        .err_count      (err_count),
        .sift_count     (sift_count),
        .resend         (resend)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one record at the falling edge; outputs are checked one edge later.
    task automatic put(input bit v, input bit m, input bit t, input bit r, input bit fs);
        @(negedge clk);
        in_valid       = v;
        in_basis_match = m;
        in_tx_bit      = t;
        in_rx_bit      = r;
        frame_start    = fs;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet under reset
        chk(!key_valid && !done && !resend, "R1 flags", {key_valid, done, resend}, 0);
        chk(err_count == 0 && sift_count == 0, "R1 counts", err_count + sift_count, 0);
        rst_n = 1'b1;

        // Table walk: back-to-back frames, only the first opened by frame_start.
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < FL; i++) begin
                put(1'b1, VEC[v].mask[i], VEC[v].tx[i], VEC[v].rx[i], (v == 0 && i == 0));
                @(negedge clk);
                // R2/R3: key strobe only for matched positions, carrying rx
                chk(key_valid == VEC[v].mask[i], "R2/R3 key_valid", key_valid, VEC[v].mask[i]);
                if (VEC[v].mask[i])
                    chk(key_bit == VEC[v].rx[i], "R2 key_bit", key_bit, VEC[v].rx[i]);
                // R5: done only after the last record; R10 frames restart alone
                chk(done == (i == FL - 1), "R5 done timing", done, (i == FL - 1));
                #0;
                in_valid = 1'b0;
                frame_start = 1'b0;
                #1;
            end
            // done is visible now, counts R4/R6, verdict R7/R8
            chk(err_count == VEC[v].exp_err, "R4 err_count", err_count, VEC[v].exp_err);
            chk(sift_count == VEC[v].exp_sift, "R6 sift_count", sift_count, VEC[v].exp_sift);
            chk(resend == VEC[v].exp_resend, "R7/R8 resend", resend, VEC[v].exp_resend);
        end

        // R6: results hold and done drops after the pulse
        put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk(!done, "R5 done drops", done, 0);
        chk(err_count == 0 && sift_count == 4 && !resend, "R6 hold", sift_count, 4);

        // R9: three errored records, then restart with a concurrent record
        for (int i = 0; i < 3; i++) put(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        put(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 6; i++) begin
            put(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
            chk(!done, "R9 no early done", done, 0);
            if (i == 2) begin
                // R5: idle gap inside the frame does not advance it
                in_valid = 1'b0;
                @(negedge clk);
                chk(!done && !key_valid, "R5 gap", done, 0);
            end
            #0 in_valid = 1'b0;
        end
        put(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);   // eighth record of the new frame
        @(negedge clk);
        chk(done, "R9 done after restart", done, 1);
        chk(err_count == 0 && sift_count == 8, "R9 totals", err_count, 0);
        chk(!resend, "R9 resend", resend, 0);
        in_valid = 1'b0;

        // R1: reset mid-frame clears outputs
        put(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!key_valid && !done && err_count == 0 && sift_count == 0, "R1 mid reset",
            sift_count, 0);
        finish_run();
    end

endmodule